// File: doc/BRIEF.md
# Vector Register Lazy-Zero Tracker

This block sits between the vector pipeline and the vector register storage. It makes reconfiguration clear registers without scrubbing any storage. Each architectural register carries a live bit. A reconfiguration event drops the live bit of one register, or of every register. While a register's live bit is low, its reads return zero. The next legal write to that register stores the data and raises the bit again.

A reconfiguration event carries the target register, its old and new element width, its old and new number format, the global width cap, and a flag that marks a change able to alter the maximum vector length. From these the block chooses between keeping state, clearing one register, and clearing every register, or it rejects the event. Registers `0 .. act_cnt-1` are enabled and the rest are disabled. Any access to a disabled register raises the illegal flag.

Reads have one cycle of latency. The read data and the illegal flag both appear one clock after the request.

Top module: `vreg_zero_track`

## Requirements
- R1: After reset, every register reads as zero and `illegal` is low.
- R2: A legal write stores its data and marks the register live at that edge. A read issued on a later cycle returns that data.
- R3: With `cfg_max_ew` = 0 and `cfg_new_ew` = `cfg_old_ew`, an event clears only the target register, even when the format is unchanged. Other registers keep their data.
- R4: With `cfg_max_ew` = 0 and `cfg_new_ew` different from `cfg_old_ew`, an event clears every register.
- R5: With `cfg_max_ew` non-zero and `cfg_new_ew` <= `cfg_max_ew`, a change in width or format clears only the target register.
- R6: With `cfg_max_ew` non-zero and `cfg_new_ew` > `cfg_max_ew`, the event raises `illegal` one cycle later and clears nothing.
- R7: An event with `cfg_len_chg` = 1 clears every register, whatever the widths are.
- R8: The following accesses raise `illegal` one cycle later: a read, write or event whose index is >= `act_cnt`. Such a read returns zero. Such a write stores nothing. Such an event clears nothing.
- R9: If a clear and a write hit the same register in the same cycle, the clear wins and the register reads zero afterwards.
- R10: A read in the same cycle as a write to the same register returns the value from before the write.
- R11: With `cfg_max_ew` non-zero, an event whose width and format are both unchanged clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_cnt | input | IDX_W+1 | Number of enabled registers, counted from register 0 |
| cfg_valid | input | 1 | A reconfiguration event is present this cycle |
| cfg_idx | input | IDX_W | Register that the event targets |
| cfg_old_ew | input | EW_W | Element width before the event |
| cfg_new_ew | input | EW_W | Element width after the event |
| cfg_old_fmt | input | FMT_W | Number format before the event |
| cfg_new_fmt | input | FMT_W | Number format after the event |
| cfg_max_ew | input | EW_W | Global width cap; 0 means no cap |
| cfg_len_chg | input | 1 | The event can alter the maximum vector length |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Write register index |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Read register index |
| rd_data | output | DATA_W | Read data after zero substitution, one cycle after the request |
| illegal | output | 1 | Illegal access or event, one cycle after the request |

## Verification
The bench sets up three situations with `cfg_max_ew` = 0:
- It rewrites a register with an unchanged width and checks that the register clears. A design that skipped this clear would return stale data.
- It changes the width and checks that every register clears. A design that cleared only the target would leave data in the other registers.
- It checks that the untouched registers still hold their data after a single-register clear. A design that confused the two cases would wipe those neighbours.

With a non-zero cap, the bench requests a width above the cap and then rewrites an identical configuration. It checks that neither event clears data. A design that missed the rejection, or that cleared on every event, would return zeros here.

The bench also issues a clear and a write to the same register in one cycle. If the write won, the old contents would reappear. It also issues accesses beyond `act_cnt`. If those were not rejected, a later legal read would show the ignored write's data.

// File: rtl/vzt_pkg.sv
package vzt_pkg;
  typedef enum logic [1:0] {
    VZ_KEEP = 2'd0,
    VZ_ONE  = 2'd1,
    VZ_ALL  = 2'd2
  } vz_clr_e;
endpackage

// File: rtl/vzt_clear_ctrl.sv
module vzt_clear_ctrl
  import vzt_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int EW_W  = 6,
  parameter int FMT_W = 5
) (
  input  logic             cfg_valid,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [EW_W-1:0]  cfg_old_ew,
  input  logic [EW_W-1:0]  cfg_new_ew,
  input  logic [FMT_W-1:0] cfg_old_fmt,
  input  logic [FMT_W-1:0] cfg_new_fmt,
  input  logic [EW_W-1:0]  cfg_max_ew,
  input  logic             cfg_len_chg,
  input  logic [IDX_W:0]   act_cnt,
  output vz_clr_e          clr_kind,
  output logic             cfg_bad
);
  logic idx_off, over_cap, ew_diff, fmt_diff, cap_zero;

  always_comb begin
    idx_off  = {1'b0, cfg_idx} >= act_cnt;
    cap_zero = (cfg_max_ew == '0);
    over_cap = !cap_zero && (cfg_new_ew > cfg_max_ew);
    ew_diff  = (cfg_new_ew != cfg_old_ew);
    fmt_diff = (cfg_new_fmt != cfg_old_fmt);
    cfg_bad  = cfg_valid && (idx_off || over_cap);
    clr_kind = VZ_KEEP;
    if (cfg_valid && !cfg_bad) begin
      if (cfg_len_chg)           clr_kind = VZ_ALL;
      else if (cap_zero)         clr_kind = ew_diff ? VZ_ALL : VZ_ONE;
      else if (ew_diff || fmt_diff) clr_kind = VZ_ONE;
    end
  end
endmodule

// File: rtl/vzt_flags.sv
module vzt_flags
  import vzt_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vz_clr_e          clr_kind,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [NREGS-1:0] live_q
);
  logic [NREGS-1:0] live_d;
  logic             live_ce;

  always_comb begin
    live_ce = set_en || (clr_kind != VZ_KEEP);
    live_d  = live_q;
    if (set_en)              live_d[set_idx] = 1'b1;
    if (clr_kind == VZ_ONE)  live_d[clr_idx] = 1'b0;
    if (clr_kind == VZ_ALL)  live_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= '0;
    else if (live_ce) live_q <= live_d;
  end

  // R4 R7
  all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_kind == VZ_ALL) |=> (live_q == '0));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && clr_kind == VZ_ONE && clr_idx == set_idx) |=> !live_q[$past(set_idx)]);

  // R2
  set_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && clr_kind == VZ_KEEP) |=> live_q[$past(set_idx)]);

  // R3 R5
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_kind == VZ_ONE && !(set_en && set_idx == clr_idx)) |=> !live_q[$past(clr_idx)]);
endmodule

// File: rtl/vzt_store.sv
module vzt_store #(
  parameter int NREGS  = 32,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/vreg_zero_track.sv
module vreg_zero_track
  import vzt_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int DATA_W = 64,
  parameter int EW_W   = 6,
  parameter int FMT_W  = 5,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W:0]    act_cnt,
  input  logic              cfg_valid,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [EW_W-1:0]   cfg_old_ew,
  input  logic [EW_W-1:0]   cfg_new_ew,
  input  logic [FMT_W-1:0]  cfg_old_fmt,
  input  logic [FMT_W-1:0]  cfg_new_fmt,
  input  logic [EW_W-1:0]   cfg_max_ew,
  input  logic              cfg_len_chg,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              illegal
);
  vz_clr_e           clr_kind;
  logic              cfg_bad;
  logic [NREGS-1:0]  live_q;
  logic [DATA_W-1:0] raw_q;
  logic              wr_ok, rd_ok, ill_d, hit_d, hit_q, ill_q;

  vzt_clear_ctrl #(.IDX_W(IDX_W), .EW_W(EW_W), .FMT_W(FMT_W)) i_ctrl (
    .cfg_valid, .cfg_idx, .cfg_old_ew, .cfg_new_ew, .cfg_old_fmt,
    .cfg_new_fmt, .cfg_max_ew, .cfg_len_chg, .act_cnt,
    .clr_kind, .cfg_bad
  );

  always_comb begin
    wr_ok = wr_en && ({1'b0, wr_idx} < act_cnt);
    rd_ok = rd_en && ({1'b0, rd_idx} < act_cnt);
    ill_d = (wr_en && !wr_ok) || (rd_en && !rd_ok) || cfg_bad;
    hit_d = rd_ok && live_q[rd_idx];
  end

  vzt_flags #(.NREGS(NREGS), .IDX_W(IDX_W)) i_flags (
    .clk, .rst_n, .clr_kind, .clr_idx(cfg_idx),
    .set_en(wr_ok), .set_idx(wr_idx), .live_q
  );

  vzt_store #(.NREGS(NREGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_store (
    .clk, .we(wr_ok), .waddr(wr_idx), .wdata(wr_data),
    .re(rd_ok), .raddr(rd_idx), .rdata_q(raw_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      ill_q <= ill_d;
    end
  end

  assign rd_data = hit_q ? raw_q : '0;
  assign illegal = ill_q;

  // R8
  off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ({1'b0, rd_idx} >= act_cnt)) |=> (illegal && rd_data == '0));

  // R6
  over_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_max_ew != '0 && cfg_new_ew > cfg_max_ew) |=> illegal);

  // R6 R8
  bad_cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bad && !wr_ok) |=> $stable(live_q));
endmodule

// File: tb/test_vreg_zero_track.sv
module test_vreg_zero_track;
  localparam int NREGS = 32;
  localparam int DW    = 64;

  typedef struct packed {
    logic          c, w, r;
    logic [4:0]    idx;
    logic [DW-1:0] wd;
    logic [5:0]    oe, ne;
    logic [4:0]    of, nf;
    logic [5:0]    mx;
    logic          mvl;
    logic [DW-1:0] exp;
    logic          ill;
  } vec_t;

  function automatic vec_t mk(logic c, logic w, logic r, logic [4:0] idx,
      logic [DW-1:0] wd, logic [5:0] oe, logic [5:0] ne, logic [4:0] of,
      logic [4:0] nf, logic [5:0] mx, logic mvl, logic [DW-1:0] exp, logic ill);
    mk = '{c, w, r, idx, wd, oe, ne, of, nf, mx, mvl, exp, ill};
  endfunction

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    mk(0,1,0, 1, 64'hA1, 0,0,0,0,0, 0, 0, 0),           // 0 wr r1
    mk(0,1,0, 2, 64'hA2, 0,0,0,0,0, 0, 0, 0),           // 1 wr r2
    mk(0,1,0, 3, 64'hA3, 0,0,0,0,0, 0, 0, 0),           // 2 wr r3
    mk(0,0,1, 1, 0, 0,0,0,0,0, 0, 64'hA1, 0),           // 3 R2
    mk(1,0,0, 1, 0, 8,8,0,1,0, 0, 0, 0),                // 4 R3 fmt change
    mk(0,0,1, 1, 0, 0,0,0,0,0, 0, 0, 0),                // 5 R3 cleared
    mk(0,0,1, 2, 0, 0,0,0,0,0, 0, 64'hA2, 0),           // 6 R3 neighbour kept
    mk(1,0,0, 2, 0, 8,8,1,1,0, 0, 0, 0),                // 7 R3 nothing changed
    mk(0,0,1, 2, 0, 0,0,0,0,0, 0, 0, 0),                // 8 R3 cleared
    mk(0,1,0, 1, 64'hB1, 0,0,0,0,0, 0, 0, 0),           // 9
    mk(0,1,0, 2, 64'hB2, 0,0,0,0,0, 0, 0, 0),           // 10
    mk(1,0,0, 3, 0, 8,16,0,0,0, 0, 0, 0),               // 11 R4 width change
    mk(0,0,1, 1, 0, 0,0,0,0,0, 0, 0, 0),                // 12 R4
    mk(0,0,1, 2, 0, 0,0,0,0,0, 0, 0, 0),                // 13 R4
    mk(0,1,0, 1, 64'hC1, 0,0,0,0,0, 0, 0, 0),           // 14
    mk(0,1,0, 2, 64'hC2, 0,0,0,0,0, 0, 0, 0),           // 15
    mk(1,0,0, 1, 0, 16,32,1,2,32, 0, 0, 0),             // 16 R5
    mk(0,0,1, 1, 0, 0,0,0,0,0, 0, 0, 0),                // 17 R5 cleared
    mk(0,0,1, 2, 0, 0,0,0,0,0, 0, 64'hC2, 0),           // 18 R5 kept
    mk(1,0,0, 2, 0, 32,33,0,0,32, 0, 0, 1),             // 19 R6 over cap
    mk(0,0,1, 2, 0, 0,0,0,0,0, 0, 64'hC2, 0),           // 20 R6 kept
    mk(1,0,0, 2, 0, 16,16,2,2,32, 0, 0, 0),             // 21 R11
    mk(0,0,1, 2, 0, 0,0,0,0,0, 0, 64'hC2, 0),           // 22 R11 kept
    mk(1,0,0, 5, 0, 16,16,2,2,32, 1, 0, 0),             // 23 R7
    mk(0,0,1, 2, 0, 0,0,0,0,0, 0, 0, 0),                // 24 R7 cleared
    mk(1,1,0, 4, 64'hD4, 8,8,0,0,0, 0, 0, 0),           // 25 R9 clear+write
    mk(0,0,1, 4, 0, 0,0,0,0,0, 0, 0, 0),                // 26 R9
    mk(0,1,1, 4, 64'hE4, 0,0,0,0,0, 0, 0, 0),           // 27 R10 old value
    mk(0,0,1, 4, 0, 0,0,0,0,0, 0, 64'hE4, 0),           // 28 R10
    mk(0,1,0, 6, 64'hF6, 0,0,0,0,0, 0, 0, 0)            // 29
  };

  logic          clk, rst_n;
  logic [5:0]    act_cnt;
  logic          cfg_valid, cfg_len_chg, wr_en, rd_en, illegal;
  logic [4:0]    cfg_idx, wr_idx, rd_idx, cfg_old_fmt, cfg_new_fmt;
  logic [5:0]    cfg_old_ew, cfg_new_ew, cfg_max_ew;
  logic [DW-1:0] wr_data, rd_data;
  int            n_chk = 0, n_fail = 0;

  vreg_zero_track i_vreg_zero_track (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic idle();
    cfg_valid = 0; wr_en = 0; rd_en = 0; cfg_len_chg = 0;
    cfg_idx = 0; wr_idx = 0; rd_idx = 0; wr_data = 0;
    cfg_old_ew = 0; cfg_new_ew = 0; cfg_old_fmt = 0; cfg_new_fmt = 0; cfg_max_ew = 0;
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v, string tag);
    @(negedge clk);
    cfg_valid = v.c; wr_en = v.w; rd_en = v.r;
    cfg_idx = v.idx; wr_idx = v.idx; rd_idx = v.idx; wr_data = v.wd;
    cfg_old_ew = v.oe; cfg_new_ew = v.ne; cfg_old_fmt = v.of; cfg_new_fmt = v.nf;
    cfg_max_ew = v.mx; cfg_len_chg = v.mvl;
    @(negedge clk);
    check({tag, " illegal"}, DW'(illegal), DW'(v.ill));
    if (v.r) check({tag, " data"}, rd_data, v.exp);
    idle();
  endtask

  initial begin
    idle();
    act_cnt = 6'd32;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 illegal", DW'(illegal), '0);
    apply(mk(0,0,1, 0, 0, 0,0,0,0,0, 0, 0, 0), "R1 r0");
    apply(mk(0,0,1, 31, 0, 0,0,0,0,0, 0, 0, 0), "R1 r31");
    for (int k = 0; k < NV; k++) apply(VEC[k], $sformatf("vec%0d", k));
    // R8 disabled register accesses
    act_cnt = 6'd4;
    apply(mk(0,1,0, 6, 64'h99, 0,0,0,0,0, 0, 0, 1), "R8 wr");
    apply(mk(0,0,1, 6, 0, 0,0,0,0,0, 0, 0, 1), "R8 rd");
    apply(mk(1,0,0, 6, 0, 8,8,0,1,0, 0, 0, 1), "R8 cfg");
    apply(mk(0,0,1, 3, 0, 0,0,0,0,0, 0, 0, 0), "R8 edge ok");
    act_cnt = 6'd32;
    apply(mk(0,0,1, 6, 0, 0,0,0,0,0, 0, 64'hF6, 0), "R8 kept");
    check("summary-ready", '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule